// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting interval timer that runs from the system clock and advances only when a count-enable strobe from an external prescaler is high. Software writes a compare value, a starting count and a small control word through a single-cycle write port. When the count reaches the compare value the block emits a one-cycle match pulse and sets a sticky match flag. It can then return to zero so that the period repeats, or it can stop after one interval.

The timing of detection and clearing is fixed so that interval lengths are exact. The match shows in the cycle in which the count first holds the compare value. The return to zero happens on the next count-enable tick, and it replaces the increment on that tick. A repeating period therefore lasts compare+1 ticks. The first interval after starting from zero is one tick shorter. Preloading the counter with all ones makes the first interval equal to the later ones. A wrap through all ones with no match sets a sticky overflow flag.

Top module: `cmt_timer`

## Requirements
- R1: After reset the count is 0, the match pulse and both flags are low, the run state is low (stopped), the clear option is off, single-shot is off and the compare value is all ones.
- R2: While running, each cycle with `tick` high advances the count by one. While stopped, `tick` has no effect on the count. Run is control bit 0, written at address 2.
- R3: When a tick moves the count onto the compare value (address 1), `match_pulse` is high for exactly that one cycle, in which `count` first equals the compare value. `match_flag` rises in the same cycle and stays high.
- R4: With clear-on-match enabled (control bit 1), the tick after a match loads 0 instead of incrementing. Started from 0, the first match comes after C ticks and each later match after C+1 ticks, where C is the compare value.
- R5: With the counter preloaded with all ones and clear-on-match enabled, the first match also comes after C+1 ticks.
- R6: In single-shot mode (control bit 2), the first match from 0 comes after C ticks. The next tick sets the count to 0 and clears the run state. Later ticks leave the count at 0 and give no match pulse.
- R7: A write to address 0 loads the counter in that cycle and overrides any increment or clear on the same tick. It also cancels a pending clear, so the next tick increments from the loaded value.
- R8: A tick that wraps the count from all ones to 0 without a match sets `ovf_flag`. The flag stays set until it is cleared.
- R9: A write to address 3 clears `match_flag` when data bit 0 is set and clears `ovf_flag` when data bit 1 is set.
- R10: With clear-on-match and single-shot both off, the counter keeps counting past the compare value after a match.
- R11: With compare value 0, clear-on-match on and the counter preloaded with all ones, every tick produces a match pulse and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| count | output | 16 | Live count value |
| match_pulse | output | 1 | One-cycle compare-match pulse |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| running | output | 1 | Run state |

## Verification
The assertions check the counter's step rules on every cycle. A counter load wins over a tick, a running tick with nothing pending adds one, a pending clear returns the count to zero, and the count holds when nothing acts on it. They also check that a match pulse only appears when the count equals the compare value, and that a single-shot clear stops the run state. The interval lengths themselves are shown only by the bench's directed scenarios. These are the short first period, the compare+1 repeat, the all-ones preload, the single-shot stop and the zero-compare case, along with the flag clear behaviour.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
   typedef enum logic [1:0] {
      SEL_COUNT   = 2'd0,
      SEL_CMP     = 2'd1,
      SEL_CTRL    = 2'd2,
      SEL_FLAGCLR = 2'd3
   } reg_sel_e;

   localparam int CTL_RUN   = 0;
   localparam int CTL_CLR   = 1;
   localparam int CTL_SHOT  = 2;

   localparam int FLG_MATCH = 0;
   localparam int FLG_OVF   = 1;
   localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
   import cmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             stop_req,
   output logic [CNT_W-1:0] cmp_val,
   output logic             run,
   output logic             clr_en,
   output logic             one_shot,
   output logic [NUM_FLAGS-1:0] flag_clr
);
   logic wr_cmp, wr_ctl, wr_fc;

   assign wr_cmp = wr_en && (wr_addr == SEL_CMP);
   assign wr_ctl = wr_en && (wr_addr == SEL_CTRL);
   assign wr_fc  = wr_en && (wr_addr == SEL_FLAGCLR);
   assign flag_clr = wr_fc ? wr_data[NUM_FLAGS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val  <= '1;
         run      <= 1'b0;
         clr_en   <= 1'b0;
         one_shot <= 1'b0;
      end else begin
         if (wr_cmp) cmp_val <= wr_data;
         if (wr_ctl) begin
            run      <= wr_data[CTL_RUN];
            clr_en   <= wr_data[CTL_CLR];
            one_shot <= wr_data[CTL_SHOT];
         end else if (stop_req) begin
            run <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             clr_en,
   input  logic             one_shot,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] count,
   output logic             match_pulse,
   output logic             hit_ev,
   output logic             ovf_ev,
   output logic             clr_pend,
   output logic             stop_req
);
   localparam logic [CNT_W-1:0] TOP_VAL = '1;

   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic             pend_q, match_q, upd;

   assign upd = tick && run && !load;

   always_comb begin
      cnt_nx = cnt_q;
      if (load)
         cnt_nx = load_val;
      else if (upd)
         cnt_nx = pend_q ? '0 : cnt_q + 1'b1;
   end

   assign stop_req = upd && pend_q && one_shot;
   assign hit_ev   = upd && !stop_req && (cnt_nx == cmp_val);
   assign ovf_ev   = upd && !pend_q && (cnt_q == TOP_VAL) && !hit_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         match_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_nx;
         match_q <= hit_ev;
         if (load)
            pend_q <= 1'b0;
         else if (hit_ev && (clr_en || one_shot))
            pend_q <= 1'b1;
         else if (upd)
            pend_q <= 1'b0;
      end
   end

   assign count       = cnt_q;
   assign match_pulse = match_q;
   assign clr_pend    = pend_q;
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags #(
   parameter int N        = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      if (SET_WINS) begin : g_setw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (clr[i]) f_q <= 1'b0;
         end
      end else begin : g_clrw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (clr[i]) f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
         end
      end
      assign flags[i] = f_q;
   end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
   import cmt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count,
   output logic             match_pulse,
   output logic             match_flag,
   output logic             ovf_flag,
   output logic             running
);
   if (CNT_W < 4) begin : g_bad_width
      $error("cmt_timer: CNT_W must be at least 4");
   end

   logic [CNT_W-1:0]     cmp_val;
   logic                 run, clr_en, one_shot, load;
   logic                 hit_ev, ovf_ev, clr_pend, stop_req;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

   assign load = wr_en && (wr_addr == SEL_COUNT);

   cmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .stop_req(stop_req), .cmp_val(cmp_val),
      .run(run), .clr_en(clr_en), .one_shot(one_shot), .flag_clr(flag_clr)
   );

   cmt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clr_en(clr_en),
      .one_shot(one_shot), .load(load), .load_val(wr_data),
      .cmp_val(cmp_val), .count(count), .match_pulse(match_pulse),
      .hit_ev(hit_ev), .ovf_ev(ovf_ev), .clr_pend(clr_pend),
      .stop_req(stop_req)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_MATCH] = hit_ev;
      flag_set[FLG_OVF]   = ovf_ev;
   end

   cmt_flags #(.N(NUM_FLAGS), .SET_WINS(SET_WINS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flag_q)
   );

   assign match_flag = flag_q[FLG_MATCH];
   assign ovf_flag   = flag_q[FLG_OVF];
   assign running    = run;
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp_val,
   input logic             match_pulse,
   input logic             match_flag,
   input logic             running,
   input logic             one_shot,
   input logic             clr_pend
);
   logic ld, step, ctlw;
   assign ld   = wr_en && (wr_addr == 2'd0);
   assign ctlw = wr_en && (wr_addr == 2'd2);
   assign step = tick && running && !ld;

   assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (count == $past(wr_data)));

   assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_pend) |=> (count == $past(count) + 1'b1));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !(tick && running)) |=> $stable(count));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && clr_pend) |=> (count == '0));

   assert_match_at_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> (count == cmp_val));

   assert_match_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> match_flag);

   assert_shot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && clr_pend && one_shot && !ctlw) |=> (!running && count == '0));
endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .count(count), .cmp_val(cmp_val),
   .match_pulse(match_pulse), .match_flag(match_flag), .running(running),
   .one_shot(one_shot), .clr_pend(clr_pend)
);

// File: tb/sim_cmt_timer.sv
module sim_cmt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] count;
   logic        match_pulse, match_flag, ovf_flag, running;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cmt_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count(count), .match_pulse(match_pulse),
      .match_flag(match_flag), .ovf_flag(ovf_flag), .running(running)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic ticks_to_match(output int n);
      n = 0;
      for (int i = 0; i < 100; i++) begin
         do_tick();
         n++;
         if (match_pulse) return;
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "count", count, 0);
      chk("R1", "match_pulse", match_pulse, 0);
      chk("R1", "match_flag", match_flag, 0);
      chk("R1", "ovf_flag", ovf_flag, 0);
      chk("R1", "running", running, 0);
   endtask

   task automatic t_stopped();
      do_reset();
      repeat (3) do_tick();
      chk("R2", "count while stopped", count, 0);
      wr(2'd2, 16'h0001);
      do_tick();
      do_tick();
      chk("R2", "count after two ticks", count, 2);
   endtask

   task automatic t_periodic();
      int n;
      do_reset();
      wr(2'd1, 16'd4);
      wr(2'd2, 16'h0003);
      ticks_to_match(n);
      chk("R4", "first interval", n, 4);
      chk("R3", "count at match", count, 4);
      chk("R3", "match_flag", match_flag, 1);
      @(negedge clk);
      chk("R3", "pulse one cycle", match_pulse, 0);
      do_tick();
      chk("R4", "cleared on next tick", count, 0);
      chk("R4", "no pulse on clear", match_pulse, 0);
      ticks_to_match(n);
      chk("R4", "rest of second interval", n + 1, 5);
      ticks_to_match(n);
      chk("R4", "third interval", n, 5);
   endtask

   task automatic t_preload();
      int n;
      do_reset();
      wr(2'd0, 16'hFFFF);
      wr(2'd1, 16'd4);
      wr(2'd2, 16'h0003);
      ticks_to_match(n);
      chk("R5", "first interval preloaded", n, 5);
      ticks_to_match(n);
      chk("R5", "second interval", n, 5);
   endtask

   task automatic t_oneshot();
      int n;
      do_reset();
      wr(2'd1, 16'd3);
      wr(2'd2, 16'h0005);
      ticks_to_match(n);
      chk("R6", "single-shot interval", n, 3);
      do_tick();
      chk("R6", "count after stop", count, 0);
      chk("R6", "running after stop", running, 0);
      n = 0;
      for (int i = 0; i < 3; i++) begin
         do_tick();
         if (match_pulse) n++;
      end
      chk("R6", "count holds", count, 0);
      chk("R6", "no further pulses", n, 0);
   endtask

   task automatic t_load();
      do_reset();
      wr(2'd1, 16'd2);
      wr(2'd2, 16'h0003);
      do_tick();
      do_tick();
      chk("R7", "reached compare", count, 2);
      tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd7;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      chk("R7", "load beats clear", count, 7);
      do_tick();
      chk("R7", "pending clear cancelled", count, 8);
   endtask

   task automatic t_ovf_noclr();
      int n;
      do_reset();
      wr(2'd1, 16'h0010);
      wr(2'd2, 16'h0001);
      wr(2'd0, 16'hFFFE);
      do_tick();
      chk("R8", "no overflow yet", ovf_flag, 0);
      do_tick();
      chk("R8", "wrapped count", count, 0);
      chk("R8", "overflow flag", ovf_flag, 1);
      chk("R8", "no match flag", match_flag, 0);
      wr(2'd3, 16'h0002);
      chk("R9", "ovf cleared", ovf_flag, 0);
      wr(2'd1, 16'd2);
      ticks_to_match(n);
      chk("R10", "match without clear", n, 2);
      chk("R9", "match flag set", match_flag, 1);
      do_tick();
      chk("R10", "counts past compare", count, 3);
      wr(2'd3, 16'h0001);
      chk("R9", "match flag cleared", match_flag, 0);
   endtask

   task automatic t_zero_cmp();
      int n;
      do_reset();
      wr(2'd0, 16'hFFFF);
      wr(2'd1, 16'd0);
      wr(2'd2, 16'h0003);
      n = 0;
      for (int i = 0; i < 4; i++) begin
         do_tick();
         if (match_pulse && count == 0) n++;
      end
      chk("R11", "pulse every tick", n, 4);
      chk("R11", "no overflow on matching wrap", ovf_flag, 0);
   endtask

   initial begin
      t_reset();
      t_stopped();
      t_periodic();
      t_preload();
      t_oneshot();
      t_load();
      t_ovf_noclr();
      t_zero_cmp();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule